// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation tables held in ordinary memory. A caller presents a linear address with a write flag and a user flag. The walker reads the top-level entry and then the second-level entry through a single 32-bit memory port, waiting for the port's ready signal on every transfer. At each level it checks the entry's present, writable and user bits against the kind of access.

When the walk succeeds, the walker reports the physical frame joined to the page offset, together with the two cache-policy bits of the leaf entry. Before it reports, it writes back any entry whose accessed bit, or whose dirty bit for a write, still has to be set. When the walk fails, no entry is modified. The linear address is kept in a fault-address register, and a one-cycle fault pulse is raised with exception vector 14.

The table base comes from a base input. Only its upper twenty bits are used, so every table sits on a 4 KB boundary.

Top module: `xlat_walker`

## Requirements
- R1: A linear address splits into top index = bits 31:22, second index = bits 21:12 and page offset = bits 11:0. The top entry is read at {base[31:12],12'h0} + 4*top index. The second entry is read at {top entry[31:12],12'h0} + 4*second index. On success, phys_addr = {second entry[31:12], lin[11:0]}.
- R2: A top entry with P (bit 0) clear, or one that fails the permission check, ends the walk with a fault after one read. The second level is never read in that case.
- R3: A second-level entry with P (bit 0) clear ends the walk with a fault after both reads.
- R4: A user access (req_user=1) faults when U (bit 2) is 0 at either level. A supervisor access never faults on U.
- R5: A user write faults when W (bit 1) is 0 at either level. Supervisor writes and all reads ignore W.
- R6: On success, a top entry with A (bit 5) clear is written back with A set, and then the second entry is written back with A set. For a write access, D (bit 6) is also set in the second entry. All other bits are written back unchanged.
- R7: No write is issued when the needed A and D bits are already set, and no write is issued at all on a walk that faults.
- R8: On a fault, fault is high for exactly one cycle, fault_addr holds the faulting linear address, and fault_vec reads 14.
- R9: A request is taken only while req_ready is high (idle). req_valid during a walk is ignored. done pulses for one cycle, and phys_addr, res_pwt and res_pcd stay unchanged until the next completed walk.
- R10: res_pwt and res_pcd give bits 3 and 4 of the second-level entry used for the translation.
- R11: Bits 11:0 of the base input have no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_lin | input | 32 | Linear address |
| req_wr | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | Top-level table base (bits 31:12 used) |
| mem_req | output | 1 | Memory transfer request, held until mem_ready |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes on this clock edge |
| done | output | 1 | One-cycle success pulse |
| phys_addr | output | 32 | Translated physical address |
| res_pwt | output | 1 | Write-through bit of the leaf entry |
| res_pcd | output | 1 | Cache-disable bit of the leaf entry |
| fault | output | 1 | One-cycle page-fault pulse |
| fault_addr | output | 32 | Faulting linear address |
| fault_vec | output | 8 | Page-fault vector number (14) |

## Verification
The bench fills a small memory with tables. It counts reads and writes, so it catches two kinds of bug: a walker that reads the second level after a top-level fault, and one that writes back entries on a walk that faults or whose bits were already set. Permission cases cover U and W cleared at each level under user and supervisor accesses. A design that checked only one level, or applied W to supervisor writes, would report done where a fault is due, or the reverse. The table indices are taken at their extremes (1023), and the base is given nonzero low bits, to expose bad address arithmetic. Requests sent while a walk is in progress must be dropped, so a walker that accepted them would return the wrong frame.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XW    = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int PAD_W = XW - IDX_W - 2;

  localparam int B_P   = 0;
  localparam int B_W   = 1;
  localparam int B_U   = 2;
  localparam int B_PWT = 3;
  localparam int B_PCD = 4;
  localparam int B_A   = 5;
  localparam int B_D   = 6;

  localparam logic [7:0] PF_VEC = 8'd14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_WB_DIR,
    ST_WB_TBL
  } walk_st_e;

  function automatic logic [IDX_W-1:0] f_top_idx(input logic [XW-1:0] lin);
    return lin[XW-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_sub_idx(input logic [XW-1:0] lin);
    return lin[OFF_W +: IDX_W];
  endfunction

  // entry slot: 4 KB aligned table start plus four bytes per index
  function automatic logic [XW-1:0] f_slot(input logic [XW-OFF_W-1:0] frame,
                                           input logic [IDX_W-1:0] idx);
    return {frame, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [XW-1:0] f_phys(input logic [XW-1:0] leaf,
                                           input logic [XW-1:0] lin);
    return {leaf[XW-1:OFF_W], lin[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [XW-1:0] entry,
  input  logic          acc_wr,
  input  logic          acc_user,
  output logic          ok,
  output logic          miss
);
  logic deny_user;
  logic deny_write;

  always_comb begin
    miss       = !entry[B_P];
    deny_user  = acc_user && !entry[B_U];
    deny_write = acc_user && acc_wr && !entry[B_W];
    ok         = !miss && !deny_user && !deny_write;
  end
endmodule

// File: rtl/xlat_mark.sv
module xlat_mark
  import xlat_pkg::*;
#(
  parameter bit LEAF = 1'b0
) (
  input  logic [XW-1:0] entry,
  input  logic          acc_wr,
  output logic [XW-1:0] upd,
  output logic          need_wb
);
  logic [XW-1:0] set_mask;

  generate
    if (LEAF) begin : g_leaf
      always_comb begin
        set_mask        = '0;
        set_mask[B_A]   = 1'b1;
        set_mask[B_D]   = acc_wr;
      end
    end else begin : g_node
      logic unused_wr;
      assign unused_wr = acc_wr;
      always_comb begin
        set_mask        = '0;
        set_mask[B_A]   = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    upd     = entry | set_mask;
    need_wb = (upd != entry);
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_lin,
  input  logic          req_wr,
  input  logic          req_user,
  input  logic [31:0]   dir_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          done,
  output logic [31:0]   phys_addr,
  output logic          res_pwt,
  output logic          res_pcd,
  output logic          fault,
  output logic [31:0]   fault_addr,
  output logic [7:0]    fault_vec
);
  walk_st_e st, st_nx;

  logic [XW-1:0]       lin_q;
  logic                wr_q;
  logic                user_q;
  logic [XW-OFF_W-1:0] base_q;
  logic [XW-1:0]       dir_q;
  logic [XW-1:0]       tbl_q;

  logic unused_bits;
  assign unused_bits = ^dir_base[OFF_W-1:0];

  // permission check on the entry arriving from memory
  logic chk_ok, chk_miss;
  xlat_perm i_perm (
    .entry   (mem_rdata),
    .acc_wr  (wr_q),
    .acc_user(user_q),
    .ok      (chk_ok),
    .miss    (chk_miss)
  );

  // leaf view: live read data while it arrives, then the held copy
  logic [XW-1:0] tbl_view;
  assign tbl_view = (st == ST_RD_TBL) ? mem_rdata : tbl_q;

  logic [XW-1:0] dir_upd, tbl_upd;
  logic          dir_need, tbl_need;

  xlat_mark #(.LEAF(1'b0)) i_mark_dir (
    .entry  (dir_q),
    .acc_wr (wr_q),
    .upd    (dir_upd),
    .need_wb(dir_need)
  );

  xlat_mark #(.LEAF(1'b1)) i_mark_tbl (
    .entry  (tbl_view),
    .acc_wr (wr_q),
    .upd    (tbl_upd),
    .need_wb(tbl_need)
  );

  // named events for the sequencer and the assertions
  logic ev_accept, ev_dir_fail, ev_tbl_fail, ev_fault, ev_finish;
  logic ev_dir_miss, ev_tbl_miss;
  logic xfer;

  assign xfer        = mem_req && mem_ready;
  assign ev_accept   = (st == ST_IDLE) && req_valid;
  assign ev_dir_fail = (st == ST_RD_DIR) && mem_ready && !chk_ok;
  assign ev_tbl_fail = (st == ST_RD_TBL) && mem_ready && !chk_ok;
  assign ev_dir_miss = ev_dir_fail && chk_miss;
  assign ev_tbl_miss = ev_tbl_fail && chk_miss;
  assign ev_fault    = ev_dir_fail || ev_tbl_fail;

  always_comb begin
    st_nx     = st;
    ev_finish = 1'b0;
    unique case (st)
      ST_IDLE:   if (req_valid) st_nx = ST_RD_DIR;
      ST_RD_DIR: if (mem_ready) st_nx = chk_ok ? ST_RD_TBL : ST_IDLE;
      ST_RD_TBL: begin
        if (mem_ready) begin
          if (!chk_ok)       st_nx = ST_IDLE;
          else if (dir_need) st_nx = ST_WB_DIR;
          else if (tbl_need) st_nx = ST_WB_TBL;
          else begin
            st_nx     = ST_IDLE;
            ev_finish = 1'b1;
          end
        end
      end
      ST_WB_DIR: begin
        if (mem_ready) begin
          if (tbl_need) st_nx = ST_WB_TBL;
          else begin
            st_nx     = ST_IDLE;
            ev_finish = 1'b1;
          end
        end
      end
      ST_WB_TBL: begin
        if (mem_ready) begin
          st_nx     = ST_IDLE;
          ev_finish = 1'b1;
        end
      end
      default:   st_nx = ST_IDLE;
    endcase
  end

  // memory port
  logic [XW-1:0] dir_slot, tbl_slot;
  assign dir_slot = f_slot(base_q, f_top_idx(lin_q));
  assign tbl_slot = f_slot(dir_q[XW-1:OFF_W], f_sub_idx(lin_q));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dir_slot;
    mem_wdata = dir_upd;
    unique case (st)
      ST_RD_DIR: mem_req = 1'b1;
      ST_RD_TBL: begin
        mem_req  = 1'b1;
        mem_addr = tbl_slot;
      end
      ST_WB_DIR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      ST_WB_TBL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tbl_slot;
        mem_wdata = tbl_upd;
      end
      default: ;
    endcase
  end

  assign req_ready = (st == ST_IDLE);
  assign fault_vec = PF_VEC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      lin_q      <= '0;
      wr_q       <= 1'b0;
      user_q     <= 1'b0;
      base_q     <= '0;
      dir_q      <= '0;
      tbl_q      <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      phys_addr  <= '0;
      res_pwt    <= 1'b0;
      res_pcd    <= 1'b0;
      fault_addr <= '0;
    end else begin
      st    <= st_nx;
      done  <= ev_finish;
      fault <= ev_fault;
      if (ev_accept) begin
        lin_q  <= req_lin;
        wr_q   <= req_wr;
        user_q <= req_user;
        base_q <= dir_base[XW-1:OFF_W];
      end
      if (st == ST_RD_DIR && mem_ready) dir_q <= mem_rdata;
      if (st == ST_RD_TBL && mem_ready) tbl_q <= mem_rdata;
      if (ev_finish) begin
        phys_addr <= f_phys(tbl_view, lin_q);
        res_pwt   <= tbl_view[B_PWT];
        res_pcd   <= tbl_view[B_PCD];
      end
      if (ev_fault) fault_addr <= lin_q;
    end
  end

  // ---------------- assertions ----------------
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r9_done_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r2_dir_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_fail |=> (fault && !mem_req));

  a_r3_tbl_miss_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tbl_miss |=> fault);

  a_r2_dir_miss_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_miss |=> fault);

  a_r6_wb_has_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_A]);

  a_r7_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_req && req_ready));

  a_r9_phys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phys_addr) |-> done);

  a_r8_faddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> fault);

  a_r9_port_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r9_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> !req_ready);
endmodule

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_wr = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] dir_base = 32'h0000_1000;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        done, fault, res_pwt, res_pcd;
  logic [31:0] phys_addr, fault_addr;
  logic [7:0]  fault_vec;

  always #2 clk = ~clk;

  xlat_walker i_xlat_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_wr(req_wr), .req_user(req_user), .dir_base(dir_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .phys_addr(phys_addr), .res_pwt(res_pwt), .res_pcd(res_pcd),
    .fault(fault), .fault_addr(fault_addr), .fault_vec(fault_vec)
  );

  logic [31:0] mem [0:4095];
  int lat = 0;
  int lat_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int n_run = 0;
  int n_fail = 0;
  logic got_done, got_fault;

  // memory model: answers after lat idle cycles, acts on the falling edge
  always @(negedge clk) begin
    if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ready = 1'b1;
        lat_cnt   = 0;
        if (mem_we) begin
          mem[mem_addr[13:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[13:2]];
          rd_cnt++;
        end
      end else begin
        mem_ready = 1'b0;
        lat_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      lat_cnt   = 0;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] lin, input logic wr, input logic usr);
    rd_cnt = 0;
    wr_cnt = 0;
    got_done = 1'b0;
    got_fault = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_wr = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    got_done = done;
    got_fault = fault;
    if (!done && !fault) check("R9 walk timeout", 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] sub_lin(input int ti, input int si, input int off);
    return (32'(ti) << 22) | (32'(si) << 12) | 32'(off);
  endfunction

  task automatic t_reset();
    check("R9 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R8 reset fault", {31'd0, fault}, 32'd0);
    check("R9 reset mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_basic();
    lat = 0;
    mem[12'h401] = 32'h0000_2027;
    mem[12'h805] = 32'hABCD_E02F;
    walk(32'h0040_5123, 1'b0, 1'b1);
    check("R1 basic done", {31'd0, got_done}, 32'd1);
    check("R1 basic phys", phys_addr, 32'hABCD_E123);
    check("R10 basic pwt", {31'd0, res_pwt}, 32'd1);
    check("R10 basic pcd", {31'd0, res_pcd}, 32'd0);
    check("R7 basic no writes", 32'(wr_cnt), 32'd0);
    check("R1 basic two reads", 32'(rd_cnt), 32'd2);
  endtask

  task automatic t_mark();
    lat = 2;
    mem[12'h402] = 32'h0000_3007;
    mem[12'hFFF] = 32'h1234_5017;
    walk(32'h00BF_FFFF, 1'b1, 1'b0);
    check("R1 max index phys", phys_addr, 32'h1234_5FFF);
    check("R10 pcd", {31'd0, res_pcd}, 32'd1);
    check("R10 pwt", {31'd0, res_pwt}, 32'd0);
    check("R6 two writebacks", 32'(wr_cnt), 32'd2);
    check("R6 top A set", mem[12'h402], 32'h0000_3027);
    check("R6 leaf A and D set", mem[12'hFFF], 32'h1234_5077);
    walk(32'h00BF_FFFF, 1'b0, 1'b1);
    check("R7 no rewrite", 32'(wr_cnt), 32'd0);
    check("R7 same phys", phys_addr, 32'h1234_5FFF);
  endtask

  task automatic t_dirty();
    lat = 1;
    walk(32'h0040_5000, 1'b1, 1'b1);
    check("R6 dirty done", {31'd0, got_done}, 32'd1);
    check("R6 dirty one write", 32'(wr_cnt), 32'd1);
    check("R6 dirty leaf", mem[12'h805], 32'hABCD_E06F);
  endtask

  task automatic t_dir_miss();
    lat = 0;
    mem[12'h403] = 32'h0000_3000;
    walk(32'h00C0_0777, 1'b0, 1'b0);
    check("R2 dir miss fault", {31'd0, got_fault}, 32'd1);
    check("R2 dir miss one read", 32'(rd_cnt), 32'd1);
    check("R8 fault addr", fault_addr, 32'h00C0_0777);
    check("R8 vector", {24'd0, fault_vec}, 32'd14);
    @(negedge clk);
    check("R8 fault one cycle", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_tbl_miss();
    lat = 2;
    mem[12'h404] = 32'h0000_2007;
    mem[12'h809] = 32'h5555_5006;
    walk(sub_lin(4, 9, 16), 1'b1, 1'b0);
    check("R3 leaf miss fault", {31'd0, got_fault}, 32'd1);
    check("R3 leaf miss reads", 32'(rd_cnt), 32'd2);
    check("R7 no write on fault", 32'(wr_cnt), 32'd0);
    check("R7 top unchanged", mem[12'h404], 32'h0000_2007);
    check("R8 fault addr leaf", fault_addr, sub_lin(4, 9, 16));
  endtask

  task automatic t_user();
    lat = 0;
    mem[12'h405] = 32'h0000_2003;
    mem[12'h80A] = 32'h6666_6007;
    walk(sub_lin(5, 10, 0), 1'b0, 1'b1);
    check("R4 top U=0 user faults", {31'd0, got_fault}, 32'd1);
    check("R2 top deny one read", 32'(rd_cnt), 32'd1);
    walk(sub_lin(5, 10, 0), 1'b0, 1'b0);
    check("R4 supervisor ok", {31'd0, got_done}, 32'd1);
    check("R4 supervisor phys", phys_addr, 32'h6666_6000);
    check("R6 A marks", 32'(wr_cnt), 32'd2);
    mem[12'h406] = 32'h0000_2027;
    mem[12'h80B] = 32'h7777_7003;
    walk(sub_lin(6, 11, 0), 1'b0, 1'b1);
    check("R4 leaf U=0 user faults", {31'd0, got_fault}, 32'd1);
    check("R4 leaf deny reads", 32'(rd_cnt), 32'd2);
  endtask

  task automatic t_wprot();
    lat = 1;
    mem[12'h407] = 32'h0000_2025;
    mem[12'h80C] = 32'h8888_8027;
    walk(sub_lin(7, 12, 4), 1'b1, 1'b1);
    check("R5 top W=0 user write faults", {31'd0, got_fault}, 32'd1);
    walk(sub_lin(7, 12, 4), 1'b0, 1'b1);
    check("R5 user read ok", {31'd0, got_done}, 32'd1);
    check("R7 user read no write", 32'(wr_cnt), 32'd0);
    walk(sub_lin(7, 12, 4), 1'b1, 1'b0);
    check("R5 supervisor write ok", {31'd0, got_done}, 32'd1);
    check("R5 supervisor write D", mem[12'h80C], 32'h8888_8067);
    mem[12'h408] = 32'h0000_2027;
    mem[12'h80D] = 32'h9999_9025;
    walk(sub_lin(8, 13, 0), 1'b1, 1'b1);
    check("R5 leaf W=0 user write faults", {31'd0, got_fault}, 32'd1);
    walk(sub_lin(8, 13, 0), 1'b1, 1'b0);
    check("R5 leaf supervisor write ok", {31'd0, got_done}, 32'd1);
  endtask

  task automatic t_base_low();
    lat = 0;
    dir_base = 32'h0000_1ABC;
    walk(32'h0040_5123, 1'b0, 1'b0);
    check("R11 base low bits ignored", phys_addr, 32'hABCD_E123);
    mem[12'h7FF] = 32'h0000_2027;
    mem[12'h800] = 32'hCAFE_0027;
    walk(32'hFFC0_0ABC, 1'b0, 1'b0);
    check("R1 top index 1023", phys_addr, 32'hCAFE_0ABC);
    dir_base = 32'h0000_1000;
  endtask

  task automatic t_busy();
    int hold_rd;
    lat = 3;
    rd_cnt = 0;
    wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_lin = 32'h0040_5123; req_wr = 1'b0; req_user = 1'b0;
    @(negedge clk);
    check("R9 busy not ready", {31'd0, req_ready}, 32'd0);
    req_lin = 32'h00BF_FFFF;
    for (int k = 0; k < 400; k++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check("R9 busy request ignored", phys_addr, 32'hABCD_E123);
    @(negedge clk);
    check("R9 done one cycle", {31'd0, done}, 32'd0);
    hold_rd = rd_cnt;
    repeat (5) @(negedge clk);
    check("R9 phys stable", phys_addr, 32'hABCD_E123);
    check("R9 no walk after", 32'(rd_cnt), 32'(hold_rd));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_mark();
    t_dirty();
    t_dir_miss();
    t_tbl_miss();
    t_user();
    t_wprot();
    t_base_low();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule